// File: doc/BRIEF.md
# Compensated Approximate Squarer

This block squares an unsigned N-bit operand and returns a 2N-bit result. It does not sum a full array of partial products. It keeps the diagonal contribution of every operand bit and adds the two cross products nearest each diagonal as compensation. Each farther cross product is merged into its target bit with an OR. Because of that merge, the result can fall short of the true square, but it never exceeds it. The structure is a chain of small stages. Each stage extends the square of the low bits by one more operand bit, so no single adder spans the whole word.

A build-time switch adds a patch stage for the 4-bit case. It maps the two known short results onto the exact squares. A second switch places a register on the output, with an active-low asynchronous reset. The block suits error-tolerant datapaths such as distance metrics, where a small, bounded under-estimate is acceptable.

Top module: `sq_approx`

## Requirements
- R1: Every operand below 8 gives its exact square at any width N of 2 or more.
- R2: Result bit 0 equals operand bit 0, and result bit 1 is always 0.
- R3: Result bit 2 equals operand bit 1 AND NOT operand bit 0.
- R4: A zero operand gives a zero result.
- R5: The result never exceeds the exact square of the operand.
- R6: Cross products farther than two positions from a diagonal are ORed into their target bit. For N=4, operand 13 gives 153 and operand 15 gives 209, and the other 14 operands give exact squares.
- R7: For N=4, result bit 7 equals operand bit 3 AND operand bit 2.
- R8: With the patch enabled and N=4, result 153 becomes 169 and 209 becomes 225, so all 16 operands give exact squares.
- R9: With the output register enabled, the result appears on the first rising clock edge after the operand. While rst_ni is low the output is 0, whatever the operand.
- R10: For N=4 without the patch, the worst-case relative error over all operands is 9.47% (within 0.01 points). The mean over all 16 operands, with zero counted as error-free, is 1.04% (within 0.01 points).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | N | Unsigned operand |
| sq_o | output | 2N | Approximate square of the operand |

## Verification
The bench sweeps every operand and compares each one against an exact square. It also requires that the result never rise above that square; a stage that ORed a near cross product instead of adding it would drop whole carries and break that match. The two colliding operands, 13 and 15, are checked for their exact short codes. A design that added the far term with a carry would return 169 and 225 there, and a wrong patch would leave 153 or 209 on the corrected instance. The low bits and the top bit are checked by their own rules, because a misplaced shift shows up there first. The register latency and the asynchronous clear are checked by sampling just before and after an edge, and while reset is held with a nonzero operand.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // known short results of the 4-bit approximation and their exact squares
  localparam logic [7:0] SQ4_SHORT_A = 8'd153;
  localparam logic [7:0] SQ4_EXACT_A = 8'd169;
  localparam logic [7:0] SQ4_SHORT_B = 8'd209;
  localparam logic [7:0] SQ4_EXACT_B = 8'd225;

  localparam int unsigned SQ_MIN_WIDTH = 2;
endpackage

// File: rtl/sq_stage.sv
// Extends the square of a[K-1:0] by operand bit K.
module sq_stage #(
  parameter int unsigned K = 1
) (
  input  logic [K:0]       a_i,
  input  logic [2*K-1:0]   r_prev_i,
  output logic [2*K+1:0]   r_o
);
  localparam int unsigned W = 2 * K + 2;

  logic [W-1:0] prev_ext;
  logic [W-1:0] t_pure;
  logic [W-1:0] t_near1;
  logic [W-1:0] t_near2;
  logic [W-1:0] far_mask;
  logic [W-1:0] near_sum;

  assign prev_ext = {2'b00, r_prev_i};
  assign t_pure   = W'(1) << (2 * K);
  // a_K*a_(K-1) has weight 2^(2K)
  assign t_near1  = a_i[K-1] ? t_pure : '0;

  generate
    if (K >= 2) begin : g_near2
      // a_K*a_(K-2) has weight 2^(2K-1)
      assign t_near2 = a_i[K-2] ? (W'(1) << (2 * K - 1)) : '0;
    end else begin : g_no_near2
      assign t_near2 = '0;
    end
  endgenerate

  // a_K*a_j for j <= K-3 lands on bit K+1+j, merged without carry
  always_comb begin
    far_mask = '0;
    for (int j = 0; j + 3 <= int'(K); j++) begin
      far_mask[K+1+j] = a_i[j];
    end
  end

  assign near_sum = prev_ext + t_pure + t_near1 + t_near2;
  assign r_o      = a_i[K] ? (near_sum | far_mask) : prev_ext;
endmodule

// File: rtl/sq_fix.sv
module sq_fix #(
  parameter int unsigned N      = 4,
  parameter bit          FIX_EN = 1'b0
) (
  input  logic [2*N-1:0] r_i,
  output logic [2*N-1:0] r_o
);
  import sq_pkg::*;

  generate
    if (FIX_EN && N == 4) begin : g_patch
      always_comb begin
        unique case (r_i)
          SQ4_SHORT_A: r_o = SQ4_EXACT_A;
          SQ4_SHORT_B: r_o = SQ4_EXACT_B;
          default:     r_o = r_i;
        endcase
      end
    end else begin : g_pass
      assign r_o = r_i;
    end
  endgenerate
endmodule

// File: rtl/sq_outreg.sv
module sq_outreg #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end

      AST_REG_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (q_o == $past(d_i))) else $error("output register lag");  // R9
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/sq_approx.sv
module sq_approx #(
  parameter int unsigned N       = 4,
  parameter bit          FIX_EN  = 1'b0,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   a_i,
  output logic [2*N-1:0] sq_o
);
  import sq_pkg::*;

  localparam int unsigned RW = 2 * N;

  logic [RW-1:0] r_apx;
  logic [RW-1:0] r_fix;
  logic [RW-1:0] exact_sq;

  initial begin
    if (N < SQ_MIN_WIDTH) $error("sq_approx: N below minimum");
  end

  // one stage per operand bit above bit 0
  generate
    for (genvar k = 1; k < N; k++) begin : g_st
      logic [2*k+1:0] r;
      if (k == 1) begin : g_first
        sq_stage #(.K(k)) u_stage (
          .a_i      (a_i[k:0]),
          .r_prev_i ({1'b0, a_i[0]}),
          .r_o      (r)
        );
      end else begin : g_next
        sq_stage #(.K(k)) u_stage (
          .a_i      (a_i[k:0]),
          .r_prev_i (g_st[k-1].r),
          .r_o      (r)
        );
      end
    end
  endgenerate

  assign r_apx = g_st[N-1].r;

  sq_fix #(.N(N), .FIX_EN(FIX_EN)) u_fix (
    .r_i (r_apx),
    .r_o (r_fix)
  );

  sq_outreg #(.W(RW), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (r_fix),
    .q_o    (sq_o)
  );

  assign exact_sq = RW'(a_i) * RW'(a_i);

  AST_BIT1_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_apx[1] == 1'b0) else $error("bit 1 set");  // R2
  AST_BIT0_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_apx[0] == a_i[0]) else $error("bit 0 mismatch");  // R2
  AST_BIT2_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_apx[2] == (a_i[1] & ~a_i[0])) else $error("bit 2 mismatch");  // R3
  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0) |-> (r_fix == '0)) else $error("zero operand");  // R4
  AST_NO_OVERSHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_apx <= exact_sq) else $error("above exact square");  // R5

  generate
    if (FIX_EN && N == 4) begin : g_fix_chk
      AST_FIX_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_fix == exact_sq) else $error("patched result inexact");  // R8
    end
  endgenerate
endmodule

// File: tb/sq_approx_tb_top.sv
module sq_approx_tb_top;
  localparam int unsigned N  = 4;
  localparam int unsigned RW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  a = '0;
  logic [RW-1:0] sq;
  logic [RW-1:0] sq_fx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  sq_approx #(.N(N), .FIX_EN(1'b0), .REG_OUT(1'b1)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .a_i (a), .sq_o (sq)
  );

  sq_approx #(.N(N), .FIX_EN(1'b1), .REG_OUT(1'b1)) dut_fix_i (
    .clk_i (clk), .rst_ni (rst_n), .a_i (a), .sq_o (sq_fx)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int unsigned v);
    @(negedge clk);
    a = N'(v);
    @(posedge clk);
    #1ns;
  endtask

  function automatic int unsigned model_apx(input int unsigned v);
    if (v == 13) return 153;  // R6 collision on bit 4
    if (v == 15) return 209;  // R6
    return v * v;
  endfunction

  task automatic t_reset;
    a = N'(15);
    #5ns;
    check(sq == '0, "R9 reset state", sq, 0);
    check(sq_fx == '0, "R9 reset state fix", sq_fx, 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3);
    check(sq == RW'(9), "R9 first result", sq, 9);
    @(negedge clk);
    rst_n = 1'b0;
    #1ns;
    check(sq == '0, "R9 async clear", sq, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep;
    real max_e = 0.0;
    real sum_e = 0.0;
    for (int v = 0; v < 2**N; v++) begin
      int unsigned ex = v * v;
      int unsigned ap = model_apx(v);
      drive(v);
      check(sq == RW'(ap), "R6 approx value", sq, ap);
      check(sq <= RW'(ex), "R5 not above exact", sq, ex);
      check(sq[0] == a[0] && sq[1] == 1'b0, "R2 low bits", sq[1:0], {1'b0, a[0]});
      check(sq[2] == (a[1] & ~a[0]), "R3 bit 2", sq[2], a[1] & ~a[0]);
      check(sq[7] == (a[3] & a[2]), "R7 top bit", sq[7], a[3] & a[2]);
      if (v < 8) check(sq == RW'(ex), "R1 exact below 8", sq, ex);
      if (v == 0) check(sq == '0, "R4 zero", sq, 0);
      if (v > 0) begin
        real e = (real'(ex) - real'(sq)) / real'(ex) * 100.0;
        sum_e += e;
        if (e > max_e) max_e = e;
      end
    end
    $display("N=%0d worst error %0.2f%%, mean error %0.2f%%", N, max_e, sum_e / real'(2**N));
    check(max_e > 9.46 && max_e < 9.48, "R10 worst error", longint'(max_e * 100.0), 947);
    check((sum_e / 16.0) > 1.03 && (sum_e / 16.0) < 1.05, "R10 mean error",
          longint'(sum_e / 16.0 * 100.0), 104);
  endtask

  task automatic t_fix;
    int bad = 0;
    for (int v = 0; v < 2**N; v++) begin
      drive(v);
      if (sq_fx != RW'(v * v)) bad++;
      if (v == 13) check(sq_fx == RW'(169), "R8 patch 153", sq_fx, 169);
      if (v == 15) check(sq_fx == RW'(225), "R8 patch 209", sq_fx, 225);
    end
    check(bad == 0, "R8 zero mismatches", bad, 0);
  endtask

  task automatic t_latency;
    drive(5);
    @(negedge clk);
    a = N'(6);
    #1ns;
    check(sq == RW'(25), "R9 held before edge", sq, 25);
    @(posedge clk);
    #1ns;
    check(sq == RW'(36), "R9 updated after edge", sq, 36);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_fix();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule